// File: doc/BRIEF.md
# Programmable RGB display timing generator

This block produces the raster timing for a parallel RGB panel. It drives horizontal sync, vertical sync, a data-enable strobe and the current active-pixel coordinates. Every line and every frame is built from four programmed segment lengths: sync, back porch, active and front porch. Each length register holds the real length minus one. A pixel strobe comes from an integer divider of the source clock. A pixel-clock level output is also provided. Each of these outputs can be inverted on its own.

A frame interrupt pulses for one clock. A select input places it either at the start of the vertical sync of a new frame or at the start of the vertical front porch. Output runs only while both the enable and the deferred enable are high. Dropping either one returns every output to idle. The next start always begins at the first pixel of horizontal and vertical sync. Pixel data itself is produced elsewhere and qualified by the data-enable and coordinate outputs.

Top module: `disp_timing_gen`

## Requirements
- R1: Each line runs through horizontal sync, back porch, active and front porch, in that order. Each segment lasts its register value plus one pixel. The horizontal sync output is active only during the sync segment.
- R2: Each frame runs through vertical sync, back porch, active and front porch lines, in that order. Each segment lasts its register value plus one line. Vertical sync is active for every pixel of its sync lines.
- R3: Data-enable is active only when the horizontal and vertical positions are both in their active segments.
- R4: `pix_x` is the pixel index inside the active part of the line, and `pix_y` is the line index inside the active lines. Each of them is 0 outside its active segment.
- R5: The divider count register holds the divisor minus one. Each pixel lasts that many source clocks. `pclk_en` is high on the last source clock of every pixel. With divisor 1 it stays high on every clock.
- R6: A divider register value above 255 behaves as divisor 256.
- R7: Before inversion, `pclk` is high on the source clocks of a pixel whose phase (0 to divisor-1) is at least divisor/2, rounded down. It is low while stopped.
- R8: Setting `inv_hsync`, `inv_vsync`, `inv_de` or `inv_pclk` inverts only its own output, both while running and while idle.
- R9: `frame_irq` is a one-clock pulse on the first source clock of a frame segment. With `irq_at_front` = 0 the segment is the vertical sync of every frame after the first. With `irq_at_front` = 1 it is the first vertical front-porch line.
- R10: Output runs only while `vid_en` and `vid_en_defer` are both 1. The first output clock is two rising edges after both are seen high, and it shows the first sync pixel. Two edges after either one drops, all outputs are idle.
- R11: While in reset or idle, sync, data-enable and pixel clock sit at their inactive level (the inversion bit). `pclk_en`, the coordinates and `frame_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_en | input | 1 | Video enable |
| vid_en_defer | input | 1 | Deferred video enable, also required |
| clk_div_m1 | input | DIV_W | Pixel divisor minus one, clamped to 255 |
| h_sync_m1 | input | HW | Horizontal sync width minus one |
| h_back_m1 | input | HW | Horizontal back porch minus one |
| h_act_m1 | input | HW | Active pixels per line minus one |
| h_front_m1 | input | HW | Horizontal front porch minus one |
| v_sync_m1 | input | VW | Vertical sync lines minus one |
| v_back_m1 | input | VW | Vertical back porch lines minus one |
| v_act_m1 | input | VW | Active lines minus one |
| v_front_m1 | input | VW | Vertical front porch lines minus one |
| inv_hsync | input | 1 | Invert horizontal sync |
| inv_vsync | input | 1 | Invert vertical sync |
| inv_de | input | 1 | Invert data-enable |
| inv_pclk | input | 1 | Invert pixel-clock level |
| irq_at_front | input | 1 | 1: interrupt at vertical front porch, 0: at frame start |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data-enable |
| pclk | output | 1 | Pixel-clock level |
| pclk_en | output | 1 | Pixel strobe, last source clock of each pixel |
| pix_x | output | HW | Active pixel column |
| pix_y | output | VW | Active line row |
| frame_irq | output | 1 | One-clock frame interrupt |

## Verification
All results are due at a fixed distance from the enable. The run and divider state registers at the first rising edge after both enables are seen. The output register then shows the first sync pixel after the second edge. From then on, output clock n carries pixel n/divisor, at phase n mod divisor. The bench drives inputs and samples outputs on falling edges. It waits exactly one falling edge after raising the enables before output clock 0. It computes every expected level from n and the programmed segment lengths. After the enables drop, it skips one falling edge and then expects idle levels, since the output register still holds the last running value for one clock.

// File: rtl/tg_pkg.sv
package tg_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC  = 2'd0,
    SEG_BACK  = 2'd1,
    SEG_ACT   = 2'd2,
    SEG_FRONT = 2'd3
  } seg_e;
endpackage

// File: rtl/tg_clkdiv.sv
module tg_clkdiv #(
  parameter int DIV_W   = 10,
  parameter int MAX_DIV = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_m1,
  output logic             tick,
  output logic             lvl
);
  localparam int CW = $clog2(MAX_DIV);

  logic [CW-1:0] dv;
  logic [CW-1:0] cnt;
  logic [CW:0]   half;

  // clamp oversize divisor settings to the largest divisor
  always_comb begin
    if (div_m1 > DIV_W'(MAX_DIV - 1)) dv = CW'(MAX_DIV - 1);
    else                              dv = div_m1[CW-1:0];
  end

  assign half = ({1'b0, dv} + (CW+1)'(1)) >> 1;
  assign tick = run && (cnt >= dv);
  assign lvl  = run && ({1'b0, cnt} >= half);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/tg_axis.sv
module tg_axis
  import tg_pkg::*;
#(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         step,
  input  logic [W-1:0] len_sync,
  input  logic [W-1:0] len_back,
  input  logic [W-1:0] len_act,
  input  logic [W-1:0] len_front,
  output seg_e         seg,
  output logic [W-1:0] cnt,
  output logic         wrap,
  output logic         into_front
);
  logic [W-1:0] cur_len;
  logic         seg_end;

  always_comb begin
    case (seg)
      SEG_SYNC: cur_len = len_sync;
      SEG_BACK: cur_len = len_back;
      SEG_ACT:  cur_len = len_act;
      default:  cur_len = len_front;
    endcase
  end

  // >= keeps a shortened segment from running away after reprogramming
  assign seg_end    = step && (cnt >= cur_len);
  assign wrap       = seg_end && (seg == SEG_FRONT);
  assign into_front = seg_end && (seg == SEG_ACT);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      seg <= SEG_SYNC;
      cnt <= '0;
    end else if (seg_end) begin
      seg <= seg_e'(seg + 2'd1);
      cnt <= '0;
    end else if (step) begin
      cnt <= cnt + W'(1);
    end
  end
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import tg_pkg::*;
#(
  parameter int HW      = 11,
  parameter int VW      = 11,
  parameter int DIV_W   = 10,
  parameter int MAX_DIV = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vid_en,
  input  logic             vid_en_defer,
  input  logic [DIV_W-1:0] clk_div_m1,
  input  logic [HW-1:0]    h_sync_m1,
  input  logic [HW-1:0]    h_back_m1,
  input  logic [HW-1:0]    h_act_m1,
  input  logic [HW-1:0]    h_front_m1,
  input  logic [VW-1:0]    v_sync_m1,
  input  logic [VW-1:0]    v_back_m1,
  input  logic [VW-1:0]    v_act_m1,
  input  logic [VW-1:0]    v_front_m1,
  input  logic             inv_hsync,
  input  logic             inv_vsync,
  input  logic             inv_de,
  input  logic             inv_pclk,
  input  logic             irq_at_front,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic             pclk,
  output logic             pclk_en,
  output logic [HW-1:0]    pix_x,
  output logic [VW-1:0]    pix_y,
  output logic             frame_irq
);
  logic          run_q;
  logic          tick, lvl;
  seg_e          h_seg, v_seg;
  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic          h_wrap, h_into_front;
  logic          v_wrap, v_into_front;
  logic          irq_ev, irq_st;

  // active-high output registers; polarity applied after them
  logic          hs_act, vs_act, de_act, pclk_act, pen_q, irq_q;
  logic [HW-1:0] px_q;
  logic [VW-1:0] py_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= vid_en && vid_en_defer;
  end

  tg_clkdiv #(.DIV_W(DIV_W), .MAX_DIV(MAX_DIV)) u_div (
    .clk(clk), .rst(rst), .run(run_q), .div_m1(clk_div_m1),
    .tick(tick), .lvl(lvl)
  );

  tg_axis #(.W(HW)) u_h (
    .clk(clk), .rst(rst), .run(run_q), .step(tick),
    .len_sync(h_sync_m1), .len_back(h_back_m1),
    .len_act(h_act_m1), .len_front(h_front_m1),
    .seg(h_seg), .cnt(h_cnt), .wrap(h_wrap), .into_front(h_into_front)
  );

  tg_axis #(.W(VW)) u_v (
    .clk(clk), .rst(rst), .run(run_q), .step(h_wrap),
    .len_sync(v_sync_m1), .len_back(v_back_m1),
    .len_act(v_act_m1), .len_front(v_front_m1),
    .seg(v_seg), .cnt(v_cnt), .wrap(v_wrap), .into_front(v_into_front)
  );

  assign irq_ev = irq_at_front ? v_into_front : v_wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_st   <= 1'b0;
      hs_act   <= 1'b0;
      vs_act   <= 1'b0;
      de_act   <= 1'b0;
      pclk_act <= 1'b0;
      pen_q    <= 1'b0;
      irq_q    <= 1'b0;
      px_q     <= '0;
      py_q     <= '0;
    end else begin
      irq_st   <= run_q && irq_ev;
      hs_act   <= run_q && (h_seg == SEG_SYNC);
      vs_act   <= run_q && (v_seg == SEG_SYNC);
      de_act   <= run_q && (h_seg == SEG_ACT) && (v_seg == SEG_ACT);
      pclk_act <= lvl;
      pen_q    <= tick;
      irq_q    <= run_q && irq_st;
      px_q     <= (run_q && h_seg == SEG_ACT) ? h_cnt : '0;
      py_q     <= (run_q && v_seg == SEG_ACT) ? v_cnt : '0;
    end
  end

  assign hsync     = hs_act ^ inv_hsync;
  assign vsync     = vs_act ^ inv_vsync;
  assign de        = de_act ^ inv_de;
  assign pclk      = pclk_act ^ inv_pclk;
  assign pclk_en   = pen_q;
  assign pix_x     = px_q;
  assign pix_y     = py_q;
  assign frame_irq = irq_q;
endmodule

// File: rtl/tg_chk.sv
module tg_chk
  import tg_pkg::*;
#(
  parameter int HW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          run_q,
  input logic          tick,
  input seg_e          h_seg,
  input logic [HW-1:0] h_cnt,
  input logic          hs_act,
  input logic          vs_act,
  input logic          de_act,
  input logic          pen_q,
  input logic          irq_q,
  input logic [HW-1:0] pix_x
);
  // R3: data-enable never overlaps either sync
  a_r3_de_outside_sync: assert property (@(posedge clk) disable iff (rst)
    de_act |-> (!hs_act && !vs_act));

  // R4: column output is zero during horizontal sync
  a_r4_x_zero_in_sync: assert property (@(posedge clk) disable iff (rst)
    hs_act |-> (pix_x == '0));

  // R5: horizontal position only moves on a pixel strobe
  a_r5_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    (run_q && !tick) |=> ($stable(h_cnt) && $stable(h_seg)));

  // R9: interrupt is a single-clock pulse
  a_r9_irq_one_clock: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);

  // R10: once stopped, the next output clock is idle
  a_r10_idle_after_stop: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> (!hs_act && !vs_act && !de_act && !pen_q && !irq_q));
endmodule

bind disp_timing_gen tg_chk #(.HW(HW)) u_chk (
  .clk(clk), .rst(rst), .run_q(run_q), .tick(tick),
  .h_seg(h_seg), .h_cnt(h_cnt), .hs_act(hs_act), .vs_act(vs_act),
  .de_act(de_act), .pen_q(pen_q), .irq_q(irq_q), .pix_x(pix_x)
);

// File: tb/disp_timing_gen_tb.sv
`timescale 1ns/1ps
module disp_timing_gen_tb;
  localparam int HW = 11;
  localparam int VW = 11;
  localparam int DIV_W = 10;
  // segment lengths (actual); registers get these minus one
  localparam int HS = 2, HB = 3, HA = 4, HF = 2;
  localparam int VS = 1, VB = 2, VA = 3, VF = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vid_en = 1'b0, vid_en_defer = 1'b0;
  logic [DIV_W-1:0] clk_div_m1 = '0;
  logic inv_hsync = 1'b0, inv_vsync = 1'b0, inv_de = 1'b0, inv_pclk = 1'b0;
  logic irq_at_front = 1'b0;
  logic hsync, vsync, de, pclk, pclk_en, frame_irq;
  logic [HW-1:0] pix_x;
  logic [VW-1:0] pix_y;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  disp_timing_gen #(.HW(HW), .VW(VW), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst(rst), .vid_en(vid_en), .vid_en_defer(vid_en_defer),
    .clk_div_m1(clk_div_m1),
    .h_sync_m1(HW'(HS-1)), .h_back_m1(HW'(HB-1)),
    .h_act_m1(HW'(HA-1)), .h_front_m1(HW'(HF-1)),
    .v_sync_m1(VW'(VS-1)), .v_back_m1(VW'(VB-1)),
    .v_act_m1(VW'(VA-1)), .v_front_m1(VW'(VF-1)),
    .inv_hsync(inv_hsync), .inv_vsync(inv_vsync), .inv_de(inv_de),
    .inv_pclk(inv_pclk), .irq_at_front(irq_at_front),
    .hsync(hsync), .vsync(vsync), .de(de), .pclk(pclk), .pclk_en(pclk_en),
    .pix_x(pix_x), .pix_y(pix_y), .frame_irq(frame_irq)
  );

  task automatic expect_val(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R11 / R10: idle levels are the inversion bits
  task automatic idle_check(input string scen, input bit [3:0] inv);
    expect_val({scen, " R11 hsync idle"}, int'(hsync), int'(inv[0]));
    expect_val({scen, " R11 vsync idle"}, int'(vsync), int'(inv[1]));
    expect_val({scen, " R11 de idle"},    int'(de),    int'(inv[2]));
    expect_val({scen, " R11 pclk idle"},  int'(pclk),  int'(inv[3]));
    expect_val({scen, " R11 pclk_en idle"}, int'(pclk_en), 0);
    expect_val({scen, " R11 pix_x idle"}, int'(pix_x), 0);
    expect_val({scen, " R11 pix_y idle"}, int'(pix_y), 0);
    expect_val({scen, " R11 irq idle"},   int'(frame_irq), 0);
  endtask

  // expected outputs for output clock n after start
  task automatic check_cycle(input string scen, input int n, input int div,
                             input bit [3:0] inv, input bit sel);
    int p, ph, hp, ln, htot, vtot;
    bit hact, vact, e_irq;
    htot = HS + HB + HA + HF;
    vtot = VS + VB + VA + VF;
    p  = n / div;
    ph = n % div;
    hp = p % htot;
    ln = (p / htot) % vtot;
    hact = (hp >= HS + HB) && (hp < HS + HB + HA);
    vact = (ln >= VS + VB) && (ln < VS + VB + VA);
    if (sel) e_irq = (ph == 0) && (hp == 0) && (ln == VS + VB + VA);
    else     e_irq = (ph == 0) && (hp == 0) && (ln == 0) && (p > 0);
    expect_val({scen, " R1 hsync"}, int'(hsync), int'((hp < HS) ^ inv[0]));
    expect_val({scen, " R2 vsync"}, int'(vsync), int'((ln < VS) ^ inv[1]));
    expect_val({scen, " R3 de"},    int'(de),    int'((hact && vact) ^ inv[2]));
    expect_val({scen, " R4 pix_x"}, int'(pix_x), hact ? hp - HS - HB : 0);
    expect_val({scen, " R4 pix_y"}, int'(pix_y), vact ? ln - VS - VB : 0);
    expect_val({scen, " R5 pclk_en"}, int'(pclk_en), int'(ph == div - 1));
    expect_val({scen, " R7 pclk"},  int'(pclk), int'((ph >= div / 2) ^ inv[3]));
    expect_val({scen, " R9 frame_irq"}, int'(frame_irq), int'(e_irq));
  endtask

  // R10: drop both enables, idle after the second edge
  task automatic stop_case(input string scen, input bit [3:0] inv);
    @(negedge clk);
    vid_en = 1'b0;
    vid_en_defer = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      idle_check({scen, " R10 stop"}, inv);
    end
  endtask

  task automatic run_case(input string scen, input int divm1, input int div,
                          input bit [3:0] inv, input bit sel, input int n_samp);
    @(negedge clk);
    clk_div_m1 = DIV_W'(divm1);
    {inv_pclk, inv_de, inv_vsync, inv_hsync} = inv;
    irq_at_front = sel;
    vid_en = 1'b1;
    vid_en_defer = 1'b1;
    @(negedge clk);
    for (int n = 0; n < n_samp; n++) begin
      @(negedge clk);
      check_cycle(scen, n, div, inv, sel);
    end
    stop_case(scen, inv);
    {inv_pclk, inv_de, inv_vsync, inv_hsync} = 4'b0000;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      idle_check("reset R11", 4'b0000);
    end
  endtask

  // R10: one enable alone never starts output
  task automatic t_half_enable;
    @(negedge clk);
    vid_en = 1'b1;
    vid_en_defer = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      idle_check("only vid_en R10", 4'b0000);
    end
    vid_en = 1'b0;
    vid_en_defer = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      idle_check("only defer R10", 4'b0000);
    end
    vid_en_defer = 1'b0;
  endtask

  initial begin
    #(4ns * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_half_enable();
    // R5 divisor 1, R9 interrupt at frame start
    run_case("div1 frame-start R5 R9", 0, 1, 4'b0000, 1'b0, 200);
    // R5 divisor 3, R9 interrupt at front porch
    run_case("div3 front R5 R9", 2, 3, 4'b0000, 1'b1, 300);
    // R8 all polarities inverted, divisor 2
    run_case("inverted R8", 1, 2, 4'b1111, 1'b1, 200);
    // R8 only sync polarities inverted
    run_case("partial invert R8", 0, 1, 4'b0011, 1'b0, 100);
    // R6 oversize divider clamps to 256
    run_case("clamp R6", 1000, 256, 4'b0000, 1'b0, 700);
    // R10 restart begins again at sync start
    run_case("restart R10", 3, 4, 4'b0000, 1'b1, 120);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule